// File: doc/BRIEF.md
# Per-Line Outstanding Request Tracker

This block sits between a processor's memory port and a cache controller. It tracks every request in flight in two small associative tables, one for read-class requests and one for write-class requests, each keyed by cache-line address. Each cycle a presented request gets one of three answers at once: issued, refused because capacity is exhausted, or refused because the same line is already in flight in either table. Refusals caused by a line conflict bump one of four stall counters, chosen by the class of the new request and the table that holds the conflicting line.

Completion inputs for reads and writes retire the matching entry and report its latency in cycles. An age watchdog arms when a request is inserted. A fixed number of cycles later it inspects every entry, and it raises a sticky deadlock error naming the first entry that has grown too old. A completion that matches no entry raises a sticky protocol error.

Top module: `line_req_tracker`

## Requirements
- R1: After reset the outstanding count, all four stall counters, `deadlock_err` and `proto_err` are zero, and with `req_valid` low `req_status` reads 3 (none).
- R2: A valid request gets status 1 (full), changes no state and no counter when `outstanding` has reached MAX_OUT, or when its own table already holds NENTRIES entries. This check ranks above the line-conflict checks.
- R3: Kind codes 2 to 9 (store, RMW read, RMW write, load-linked, store-conditional, locked read, locked write, flush) are write-class and go into the write table. Codes 0 (load), 1 (fetch) and 10 to 15 are read-class. An accepted request gets status 0 (issued) and raises `req_ready` in the same cycle.
- R4: A write-class request whose line is held in the read table gets status 2 (aliased) and increments `st_on_ld_cnt`.
- R5: A write-class request whose line is absent from the read table but present in the write table gets status 2 and increments `st_on_st_cnt`.
- R6: A read-class request whose line is in the write table gets status 2 and increments `ld_on_st_cnt`. Otherwise, if its line is in the read table, it gets status 2 and increments `ld_on_ld_cnt`.
- R7: The line address is the request address with its low log2(LINE_BYTES) bits dropped. Addresses that differ only in those bits conflict.
- R8: A completion that hits an entry removes that entry and lowers `outstanding` by one. In the completion cycle, `rd_lat`/`wr_lat` equals the current cycle number minus the cycle in which the request was accepted.
- R9: `outstanding` always equals the number of valid entries across both tables and never exceeds MAX_OUT.
- R10: The watchdog fires THRESH cycles after it is armed by an insertion. It re-arms while entries remain. At a firing, an entry aged THRESH or more sets a sticky `deadlock_err`, and `deadlock_idx` is set to {table bit, 1 = write, slot index}, with the read table and the lowest slot taking priority.
- R11: A completion whose line matches no entry in its table sets `proto_err`, which stays set until reset.
- R12: A request and a completion for the same line in the same cycle are judged against the tables as they stood before the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request presented this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_kind | input | 4 | Request kind code |
| req_ready | output | 1 | Request accepted this cycle |
| req_status | output | 2 | 0 issued, 1 full, 2 aliased, 3 none |
| rd_done_valid | input | 1 | Read completion strobe |
| rd_done_addr | input | ADDR_W | Read completion address |
| wr_done_valid | input | 1 | Write completion strobe |
| wr_done_addr | input | ADDR_W | Write completion address |
| rd_lat | output | TIME_W | Age of the read entry being completed |
| wr_lat | output | TIME_W | Age of the write entry being completed |
| outstanding | output | OUT_W | Entries in flight |
| st_on_ld_cnt | output | CNT_W | Write refused on read-table line |
| st_on_st_cnt | output | CNT_W | Write refused on write-table line |
| ld_on_st_cnt | output | CNT_W | Read refused on write-table line |
| ld_on_ld_cnt | output | CNT_W | Read refused on read-table line |
| deadlock_err | output | 1 | Sticky watchdog error |
| deadlock_idx | output | IDX_W+1 | Table bit and slot of the stale entry |
| proto_err | output | 1 | Sticky unmatched-completion error |

## Verification
A new request and the retirement of an entry can land in the same cycle, even on the same line. In that case the request must be judged on the old table contents, while the count moves by both events at once. Random traffic over only six lines, with completions and requests issued every cycle, produces this overlap often, and a directed case repeats it on one line. A bench model that keeps the pre-edge state judges the status, and it checks `outstanding` and the counters after the edge.

// File: rtl/req_tracker_pkg.sv
package req_tracker_pkg;

    typedef enum logic [1:0] {
        ST_ISSUED  = 2'd0,
        ST_FULL    = 2'd1,
        ST_ALIASED = 2'd2,
        ST_NONE    = 2'd3
    } req_status_e;

    localparam int N_STALL = 4;

    // stall event bit positions
    localparam int EV_ST_LD = 0;
    localparam int EV_ST_ST = 1;
    localparam int EV_LD_ST = 2;
    localparam int EV_LD_LD = 3;

    function automatic logic is_write_class(input logic [3:0] kind);
        return (kind >= 4'd2) && (kind <= 4'd9);
    endfunction

endpackage

// File: rtl/line_table.sv
module line_table #(
    parameter int NENTRIES = 4,
    parameter int LINE_W   = 26,
    parameter int TIME_W   = 24,
    parameter int THRESH   = 40,
    localparam int IDX_W   = (NENTRIES > 1) ? $clog2(NENTRIES) : 1,
    localparam int CNT_W   = $clog2(NENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    input  logic              ins_en,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              del_en,
    input  logic [LINE_W-1:0] del_line,
    output logic              del_hit,
    output logic [TIME_W-1:0] del_age,
    output logic              full,
    output logic [CNT_W-1:0]  occ,
    output logic              old_any,
    output logic [IDX_W-1:0]  old_idx
);

    logic [NENTRIES-1:0] vld_q, vld_d, del_match, ins_onehot;
    logic [LINE_W-1:0]   tag_q  [NENTRIES];
    logic [TIME_W-1:0]   born_q [NENTRIES];
    logic [IDX_W-1:0]    free_idx;

    always_comb begin
        look_hit  = 1'b0;
        del_hit   = 1'b0;
        del_age   = '0;
        del_match = '0;
        occ       = '0;
        for (int i = 0; i < NENTRIES; i++) begin
            if (vld_q[i] && tag_q[i] == look_line) look_hit = 1'b1;
            if (vld_q[i] && tag_q[i] == del_line) begin
                del_match[i] = 1'b1;
                del_hit      = 1'b1;
                del_age      = now - born_q[i];
            end
            occ = occ + CNT_W'(vld_q[i]);
        end
        full     = &vld_q;
        free_idx = '0;
        old_any  = 1'b0;
        old_idx  = '0;
        for (int i = NENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IDX_W'(i);
            if (vld_q[i] && (now - born_q[i]) >= TIME_W'(THRESH)) begin
                old_any = 1'b1;
                old_idx = IDX_W'(i);
            end
        end
        ins_onehot = '0;
        if (ins_en) ins_onehot[free_idx] = 1'b1;
        vld_d = (vld_q & ~(del_en ? del_match : '0)) | ins_onehot;
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_q[free_idx]  <= ins_line;
            born_q[free_idx] <= now;
        end
    end

    // R9
    ins_room_chk: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> !full);

    // R9
    occ_up_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !(del_en && del_hit)) |=> occ == $past(occ) + CNT_W'(1));

    // R8
    occ_down_chk: assert property (@(posedge clk) disable iff (rst)
        (del_en && del_hit && !ins_en) |=> occ == $past(occ) - CNT_W'(1));

endmodule

// File: rtl/deadlock_watch.sv
module deadlock_watch #(
    parameter int THRESH = 40,
    localparam int CW    = $clog2(THRESH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ins,
    input  logic keep,
    output logic fire
);

    logic          armed_q;
    logic [CW-1:0] remain_q;

    assign fire = armed_q && (remain_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            remain_q <= '0;
        end else if (fire) begin
            armed_q  <= keep;
            remain_q <= CW'(THRESH - 1);
        end else if (armed_q) begin
            remain_q <= remain_q - CW'(1);
        end else if (ins) begin
            armed_q  <= 1'b1;
            remain_q <= CW'(THRESH - 1);
        end
    end

    // R10
    fire_gap_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
    import req_tracker_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int NENTRIES   = 4,
    parameter int MAX_OUT    = 6,
    parameter int THRESH     = 40,
    parameter int CNT_W      = 16,
    parameter int TIME_W     = 24,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int IDX_W     = (NENTRIES > 1) ? $clog2(NENTRIES) : 1,
    localparam int OCC_W     = $clog2(NENTRIES + 1),
    localparam int OUT_W     = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_kind,
    output logic              req_ready,
    output logic [1:0]        req_status,
    input  logic              rd_done_valid,
    input  logic [ADDR_W-1:0] rd_done_addr,
    input  logic              wr_done_valid,
    input  logic [ADDR_W-1:0] wr_done_addr,
    output logic [TIME_W-1:0] rd_lat,
    output logic [TIME_W-1:0] wr_lat,
    output logic [OUT_W-1:0]  outstanding,
    output logic [CNT_W-1:0]  st_on_ld_cnt,
    output logic [CNT_W-1:0]  st_on_st_cnt,
    output logic [CNT_W-1:0]  ld_on_st_cnt,
    output logic [CNT_W-1:0]  ld_on_ld_cnt,
    output logic              deadlock_err,
    output logic [IDX_W:0]    deadlock_idx,
    output logic              proto_err
);

    logic [TIME_W-1:0] now_q;
    logic [LINE_W-1:0] req_line, rd_line, wr_line;
    logic              is_w, accept, rd_ins, wr_ins, rd_rm, wr_rm;
    logic              rd_hit, wr_hit, rd_full, wr_full, rd_dhit, wr_dhit;
    logic              rd_old, wr_old, fire;
    logic [IDX_W-1:0]  rd_old_idx, wr_old_idx;
    logic [OCC_W-1:0]  rd_occ, wr_occ;
    logic [OUT_W-1:0]  out_q, out_d;
    req_status_e       status;
    logic [N_STALL-1:0] evt;
    logic [CNT_W-1:0]  stall_q [N_STALL];

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign rd_line  = rd_done_addr[ADDR_W-1:OFF_W];
    assign wr_line  = wr_done_addr[ADDR_W-1:OFF_W];
    assign is_w     = is_write_class(req_kind);

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + TIME_W'(1);
    end

    line_table #(.NENTRIES(NENTRIES), .LINE_W(LINE_W), .TIME_W(TIME_W), .THRESH(THRESH)) u_rd_tbl (
        .clk(clk), .rst(rst), .now(now_q),
        .look_line(req_line), .look_hit(rd_hit),
        .ins_en(rd_ins), .ins_line(req_line),
        .del_en(rd_done_valid), .del_line(rd_line),
        .del_hit(rd_dhit), .del_age(rd_lat),
        .full(rd_full), .occ(rd_occ),
        .old_any(rd_old), .old_idx(rd_old_idx)
    );

    line_table #(.NENTRIES(NENTRIES), .LINE_W(LINE_W), .TIME_W(TIME_W), .THRESH(THRESH)) u_wr_tbl (
        .clk(clk), .rst(rst), .now(now_q),
        .look_line(req_line), .look_hit(wr_hit),
        .ins_en(wr_ins), .ins_line(req_line),
        .del_en(wr_done_valid), .del_line(wr_line),
        .del_hit(wr_dhit), .del_age(wr_lat),
        .full(wr_full), .occ(wr_occ),
        .old_any(wr_old), .old_idx(wr_old_idx)
    );

    // request judgement against the pre-edge table state
    always_comb begin
        status = ST_ISSUED;
        evt    = '0;
        if (!req_valid) begin
            status = ST_NONE;
        end else if (out_q >= OUT_W'(MAX_OUT) || (is_w ? wr_full : rd_full)) begin
            status = ST_FULL;
        end else if (is_w) begin
            if (rd_hit) begin
                status = ST_ALIASED;
                evt[EV_ST_LD] = 1'b1;
            end else if (wr_hit) begin
                status = ST_ALIASED;
                evt[EV_ST_ST] = 1'b1;
            end
        end else begin
            if (wr_hit) begin
                status = ST_ALIASED;
                evt[EV_LD_ST] = 1'b1;
            end else if (rd_hit) begin
                status = ST_ALIASED;
                evt[EV_LD_LD] = 1'b1;
            end
        end
    end

    assign accept     = (status == ST_ISSUED);
    assign rd_ins     = accept && !is_w;
    assign wr_ins     = accept && is_w;
    assign req_ready  = accept;
    assign req_status = status;
    assign rd_rm      = rd_done_valid && rd_dhit;
    assign wr_rm      = wr_done_valid && wr_dhit;
    assign out_d      = out_q + OUT_W'(accept) - OUT_W'(rd_rm) - OUT_W'(wr_rm);
    assign outstanding = out_q;

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    generate
        for (genvar g = 0; g < N_STALL; g++) begin : g_stall
            always_ff @(posedge clk) begin
                if (rst)         stall_q[g] <= '0;
                else if (evt[g]) stall_q[g] <= stall_q[g] + CNT_W'(1);
            end
        end
    endgenerate

    assign st_on_ld_cnt = stall_q[EV_ST_LD];
    assign st_on_st_cnt = stall_q[EV_ST_ST];
    assign ld_on_st_cnt = stall_q[EV_LD_ST];
    assign ld_on_ld_cnt = stall_q[EV_LD_LD];

    deadlock_watch #(.THRESH(THRESH)) u_watch (
        .clk(clk), .rst(rst),
        .ins(accept), .keep(out_d != '0),
        .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            deadlock_err <= 1'b0;
            deadlock_idx <= '0;
        end else if (fire && !deadlock_err && (rd_old || wr_old)) begin
            deadlock_err <= 1'b1;
            deadlock_idx <= rd_old ? {1'b0, rd_old_idx} : {1'b1, wr_old_idx};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) proto_err <= 1'b0;
        else if ((rd_done_valid && !rd_dhit) || (wr_done_valid && !wr_dhit))
            proto_err <= 1'b1;
    end

    // R9
    out_sum_chk: assert property (@(posedge clk) disable iff (rst)
        32'(outstanding) == 32'(rd_occ) + 32'(wr_occ));

    // R9
    out_cap_chk: assert property (@(posedge clk) disable iff (rst)
        32'(outstanding) <= MAX_OUT);

    // R8
    retire_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rm && !wr_rm && !accept) |=> outstanding == $past(outstanding) - OUT_W'(1));

    // R10
    dl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        deadlock_err |=> deadlock_err && $stable(deadlock_idx));

    // R11
    proto_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

endmodule

// File: tb/line_req_tracker_tb.sv
`timescale 1ns/1ps
module line_req_tracker_tb;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 6;
    localparam int NE     = 4;
    localparam int MAXO   = 6;
    localparam int TH     = 40;
    localparam int TW     = 24;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic              req_valid, req_ready, rd_done_valid, wr_done_valid;
    logic [ADDR_W-1:0] req_addr, rd_done_addr, wr_done_addr;
    logic [3:0]        req_kind;
    logic [1:0]        req_status;
    logic [TW-1:0]     rd_lat, wr_lat;
    logic [2:0]        outstanding;
    logic [15:0]       c_stld, c_stst, c_ldst, c_ldld;
    logic              deadlock_err, proto_err;
    logic [2:0]        deadlock_idx;

    line_req_tracker u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_ready(req_ready), .req_status(req_status),
        .rd_done_valid(rd_done_valid), .rd_done_addr(rd_done_addr),
        .wr_done_valid(wr_done_valid), .wr_done_addr(wr_done_addr),
        .rd_lat(rd_lat), .wr_lat(wr_lat), .outstanding(outstanding),
        .st_on_ld_cnt(c_stld), .st_on_st_cnt(c_stst),
        .ld_on_st_cnt(c_ldst), .ld_on_ld_cnt(c_ldld),
        .deadlock_err(deadlock_err), .deadlock_idx(deadlock_idx),
        .proto_err(proto_err)
    );

    int n_chk = 0, n_bad = 0;
    logic [TW-1:0] tb_now;
    always @(posedge clk) begin
        if (rst) tb_now <= '0;
        else     tb_now <= tb_now + 1'b1;
    end

    // bench model
    logic [25:0]   m_rl [NE], m_wl [NE];
    bit            m_rv [NE], m_wv [NE];
    logic [TW-1:0] m_rt [NE], m_wt [NE];
    int            m_out;
    int            m_c [4];
    bit            m_proto, exp_dl;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rfind(input logic [25:0] l);
        for (int i = 0; i < NE; i++) if (m_rv[i] && m_rl[i] == l) return i;
        return -1;
    endfunction

    function automatic int wfind(input logic [25:0] l);
        for (int i = 0; i < NE; i++) if (m_wv[i] && m_wl[i] == l) return i;
        return -1;
    endfunction

    function automatic int occ_of(input bit wt);
        int n = 0;
        for (int i = 0; i < NE; i++) n += wt ? int'(m_wv[i]) : int'(m_rv[i]);
        return n;
    endfunction

    task automatic check_state();
        chk("R9 outstanding", 32'(outstanding), 32'(m_out));
        chk("R4 st_on_ld", 32'(c_stld), 32'(m_c[0]));
        chk("R5 st_on_st", 32'(c_stst), 32'(m_c[1]));
        chk("R6 ld_on_st", 32'(c_ldst), 32'(m_c[2]));
        chk("R6 ld_on_ld", 32'(c_ldld), 32'(m_c[3]));
        chk("R11 proto_err", 32'(proto_err), 32'(m_proto));
        chk("R10 deadlock_err", 32'(deadlock_err), 32'(exp_dl));
    endtask

    task automatic step(input bit rv, input logic [31:0] ra, input logic [3:0] rk,
                        input bit dr, input logic [31:0] dra,
                        input bit dw, input logic [31:0] dwa);
        logic [25:0] line;
        bit w, rh, wh;
        int es, ev, ri, wi, slot;
        logic [TW-1:0] tn;
        string tag;
        @(negedge clk);
        req_valid = rv; req_addr = ra; req_kind = rk;
        rd_done_valid = dr; rd_done_addr = dra;
        wr_done_valid = dw; wr_done_addr = dwa;
        #1;
        line = ra[31:OFF_W];
        w  = (rk >= 4'd2) && (rk <= 4'd9);
        rh = rfind(line) >= 0;
        wh = wfind(line) >= 0;
        ev = -1;
        tag = "R3 issued";
        if (!rv) begin es = 3; tag = "R1 none"; end
        else if (m_out >= MAXO || occ_of(w) >= NE) begin es = 1; tag = "R2 full"; end
        else if (w && rh)  begin es = 2; ev = 0; tag = "R4 alias"; end
        else if (w && wh)  begin es = 2; ev = 1; tag = "R5 alias"; end
        else if (!w && wh) begin es = 2; ev = 2; tag = "R6 alias"; end
        else if (!w && rh) begin es = 2; ev = 3; tag = "R6 alias"; end
        else es = 0;
        chk(tag, 32'(req_status), 32'(es));
        if (rv) chk("R3 ready", 32'(req_ready), 32'(es == 0));
        ri = dr ? rfind(dra[31:OFF_W]) : -1;
        wi = dw ? wfind(dwa[31:OFF_W]) : -1;
        if (ri >= 0) chk("R8 rd latency", 32'(rd_lat), 32'(tb_now - m_rt[ri]));
        if (wi >= 0) chk("R8 wr latency", 32'(wr_lat), 32'(tb_now - m_wt[wi]));
        tn = tb_now;
        @(posedge clk);
        #1;
        if (dr) begin
            if (ri >= 0) begin m_rv[ri] = 0; m_out--; end else m_proto = 1;
        end
        if (dw) begin
            if (wi >= 0) begin m_wv[wi] = 0; m_out--; end else m_proto = 1;
        end
        if (ev >= 0) m_c[ev]++;
        if (es == 0) begin
            slot = -1;
            for (int i = 0; i < NE; i++)
                if (slot < 0 && !(w ? m_wv[i] : m_rv[i]) && !(w ? (i == wi) : (i == ri))) slot = i;
            // a slot freed in this same cycle was not free before the edge
            if (w) begin m_wv[slot] = 1; m_wl[slot] = line; m_wt[slot] = tn; end
            else   begin m_rv[slot] = 1; m_rl[slot] = line; m_rt[slot] = tn; end
            m_out++;
        end
        check_state();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    function automatic int oldest(input bit wt);
        int b = -1;
        for (int i = 0; i < NE; i++) begin
            if (wt ? m_wv[i] : m_rv[i]) begin
                if (b < 0) b = i;
                else if ((wt ? m_wt[i] : m_rt[i]) < (wt ? m_wt[b] : m_rt[b])) b = i;
            end
        end
        return b;
    endfunction

    task automatic drain();
        int r, w;
        for (int k = 0; k < 20; k++) begin
            r = oldest(0); w = oldest(1);
            step(0, 0, 0, r >= 0, r >= 0 ? {m_rl[r], 6'd0} : 0,
                          w >= 0, w >= 0 ? {m_wl[w], 6'd0} : 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NE; i++) begin m_rv[i] = 0; m_wv[i] = 0; end
        for (int i = 0; i < 4; i++) m_c[i] = 0;
        m_out = 0; m_proto = 0; exp_dl = 0;
        rst = 1; req_valid = 0; req_addr = 0; req_kind = 0;
        rd_done_valid = 0; rd_done_addr = 0; wr_done_valid = 0; wr_done_addr = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        chk("R1 status none", 32'(req_status), 32'd3);
        check_state();

        // random traffic over six lines with random offsets (R7)
        for (int c = 0; c < 1500; c++) begin
            int r, w;
            bit dr, dw;
            logic [31:0] a;
            r = oldest(0); w = oldest(1);
            dr = (r >= 0) && (($urandom % 3 == 0) || (tb_now - m_rt[r] >= 10));
            dw = (w >= 0) && (($urandom % 3 == 0) || (tb_now - m_wt[w] >= 10));
            a = 32'h4000 + (($urandom % 6) << OFF_W) + ($urandom % 64);
            step(($urandom % 4) != 0, a, 4'($urandom % 12),
                 dr, dr ? {m_rl[r], 6'h3f} : 0,
                 dw, dw ? {m_wl[w], 6'h15} : 0);
        end
        drain();
        idle(TH + 4);

        // R7: same line, different offsets
        step(1, 32'h1000, 4'd0, 0, 0, 0, 0);
        step(1, 32'h103F, 4'd9, 0, 0, 0, 0);
        chk("R7 offset alias", 32'(m_c[0]), 32'(c_stld));
        drain();

        // R12: request and completion on one line in one cycle
        step(1, 32'h2000, 4'd1, 0, 0, 0, 0);
        step(1, 32'h2000, 4'd0, 1, 32'h2000, 0, 0);
        chk("R12 judged before retire", 32'(outstanding), 32'd0);
        step(1, 32'h2010, 4'd0, 0, 0, 0, 0);
        chk("R12 reissue", 32'(outstanding), 32'd1);
        step(1, 32'h2F00, 4'd2, 1, 32'h2000, 0, 0);
        drain();

        // R2: per-table full then total full
        for (int i = 0; i < 4; i++) step(1, 32'h3000 + i * 64, 4'd0, 0, 0, 0, 0);
        step(1, 32'h3800, 4'd1, 0, 0, 0, 0);
        chk("R2 table full", 32'(outstanding), 32'd4);
        step(1, 32'h3900, 4'd6, 0, 0, 0, 0);
        step(1, 32'h3940, 4'd3, 0, 0, 0, 0);
        step(1, 32'h3980, 4'd2, 0, 0, 0, 0);
        chk("R2 total full", 32'(outstanding), 32'd6);
        drain();
        idle(TH + 4);

        // R10: stale entry caught exactly THRESH cycles after arming
        step(1, 32'h5000, 4'd0, 0, 0, 0, 0);
        idle(TH - 1);
        chk("R10 not yet", 32'(deadlock_err), 32'd0);
        exp_dl = 1;
        idle(1);
        chk("R10 index", 32'(deadlock_idx), 32'd0);

        // R11: completion with no entry
        step(0, 0, 0, 0, 0, 1, 32'h7000);
        chk("R11 sticky", 32'(proto_err), 32'd1);
        idle(2);

        summary();
        $finish;
    end

endmodule